// File: doc/BRIEF.md
# Coprocessor Enable and Access Control

This block keeps the switch-on state and the per-instruction permission state for a SIMD and floating-point coprocessor. It holds one global enable flag and, for each of two coprocessor numbers, a 2-bit access field. Software reaches both through a small register port. Every request on that port carries a privilege flag. Requests from unprivileged code are refused: nothing changes, the read data is zero, and a fault pulse is raised.

The instruction front end presents each coprocessor instruction with the coprocessor number it targets and the current privilege level. The block answers on the same cycle with either an allow or an undefined flag. The block also drives the coprocessor enable and a clock-enable request that downstream clock gating consumes. The clock-enable request follows only the access fields. It therefore stays on while the enable flag is still low, so software can program the coprocessor before switching it on.

Top module: `cpx_enable_ctrl`

## Requirements
- R1: While reset is held, and after it is released, the enable flag is 0, both access fields are 00, cp_clk_en is 0, reg_rdata is 0 and reg_fault is 0.
- R2: A privileged write (reg_sel=1, reg_wr=1, reg_priv=1) to address 0 loads reg_wdata bit 30 into cp_enable, visible on the next cycle. All other data bits are ignored.
- R3: A privileged write to address 1 loads the field for coprocessor 0 from bits 21:20 and the field for coprocessor 1 from bits 23:22. A read of address 1 returns the two fields at the same positions, with all other bits zero.
- R4: A privileged read (reg_wr=0) drives the addressed register's value on reg_rdata one cycle after the request. reg_rdata is zero in every other cycle. Addresses 2 and 3 read as zero and ignore writes.
- R5: An unprivileged request (reg_sel=1, reg_priv=0) changes no state and returns zero data. It raises reg_fault for exactly the one cycle that follows it.
- R6: Access-field codes: 11 permits instructions at either privilege level, 01 permits them only when insn_priv=1, and 00 and 10 permit none. Code 10 is still stored and read back as written.
- R7: insn_allow is 1 only when insn_valid=1, cp_enable=1 and the field selected by insn_cp (0 or 1) permits the current privilege. insn_undef equals insn_valid and not insn_allow. Both answer combinationally from the current state.
- R8: cp_clk_en is 1 whenever at least one access field is not 00. It follows a field write on the next cycle.
- R9: cp_clk_en does not depend on the enable flag. With cp_enable=0 and a non-zero field, cp_clk_en is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 1 | Register request strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register address (0 enable, 1 access) |
| reg_wdata | input | DATA_W | Write data |
| reg_priv | input | 1 | Request comes from privileged code |
| reg_rdata | output | DATA_W | Read data, one cycle after the request |
| reg_fault | output | 1 | One-cycle pulse after an unprivileged request |
| insn_valid | input | 1 | A coprocessor instruction is presented |
| insn_cp | input | CP_IDX_W | Coprocessor number of the instruction |
| insn_priv | input | 1 | Instruction executes at privileged level |
| insn_allow | output | 1 | Instruction may execute |
| insn_undef | output | 1 | Instruction must be treated as undefined |
| cp_enable | output | 1 | Global coprocessor enable |
| cp_clk_en | output | 1 | Clock-enable request for the coprocessor |

## Verification
The bench builds the block with its default parameters: two coprocessor numbers, a 32-bit data path, a 2-bit address, the enable flag at bit 30 and the fields starting at bit 20. With these values, all four access codes on both coprocessor numbers, both privilege levels, and the two unused addresses can be reached directly. Directed steps cover the reserved code, clock-enable-without-enable, and refused requests. A long random phase then mixes privileged and unprivileged traffic with instruction checks in every cycle.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

  localparam int REG_ENABLE = 0;
  localparam int REG_ACCESS = 1;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_PRIV = 2'b01,
    ACC_RSVD = 2'b10,
    ACC_FULL = 2'b11
  } acc_t;

  // Decode of one access field against the privilege of the requester.
  function automatic logic acc_permits(logic [1:0] code, logic priv);
    case (acc_t'(code))
      ACC_FULL: acc_permits = 1'b1;
      ACC_PRIV: acc_permits = priv;
      default:  acc_permits = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cpx_rst_sync.sv
module cpx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cpx_regbank.sv
module cpx_regbank
  import cpx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int EN_BIT    = 30,
  parameter int FIELD_LSB = 20,
  parameter int NUM_CP    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   priv,
  output logic [DATA_W-1:0]      rdata,
  output logic                   fault,
  output logic                   en,
  output logic [NUM_CP-1:0][1:0] acc
);

  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(REG_ENABLE);
  localparam logic [ADDR_W-1:0] A_ACC = ADDR_W'(REG_ACCESS);

  logic                   en_q;
  logic [NUM_CP-1:0][1:0] acc_q, acc_d;
  logic [DATA_W-1:0]      rdata_q, rdata_d;
  logic                   fault_q, fault_d;
  logic                   priv_req, en_we, acc_we, rd_req;

  always_comb begin
    priv_req = sel & priv;
    en_we    = priv_req & wr & (addr == A_EN);
    acc_we   = priv_req & wr & (addr == A_ACC);
    rd_req   = priv_req & ~wr;
    fault_d  = sel & ~priv;
    rdata_d  = '0;
    for (int i = 0; i < NUM_CP; i++) begin
      acc_d[i] = wdata[FIELD_LSB + 2*i +: 2];
    end
    if (rd_req && addr == A_EN) rdata_d[EN_BIT] = en_q;
    if (rd_req && addr == A_ACC) begin
      for (int i = 0; i < NUM_CP; i++) begin
        rdata_d[FIELD_LSB + 2*i +: 2] = acc_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      acc_q   <= '0;
      rdata_q <= '0;
      fault_q <= 1'b0;
    end else begin
      if (en_we)  en_q  <= wdata[EN_BIT];
      if (acc_we) acc_q <= acc_d;
      rdata_q <= rdata_d;
      fault_q <= fault_d;
    end
  end

  assign rdata = rdata_q;
  assign fault = fault_q;
  assign en    = en_q;
  assign acc   = acc_q;

  assert_unpriv_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !priv) |=> ($stable(en_q) && $stable(acc_q) && fault_q && rdata_q == '0));

  assert_idle_rdata_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && priv && !wr) |=> (rdata_q == '0));

  assert_fault_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> $past(sel && !priv));

endmodule

// File: rtl/cpx_access_check.sv
module cpx_access_check
  import cpx_pkg::*;
#(
  parameter int NUM_CP   = 2,
  parameter int CP_IDX_W = 1
) (
  input  logic                   en,
  input  logic [NUM_CP-1:0][1:0] acc,
  input  logic                   valid,
  input  logic [CP_IDX_W-1:0]    cp_idx,
  input  logic                   priv,
  output logic                   allow,
  output logic                   undef
);

  logic [1:0] code;

  always_comb begin
    code = ACC_NONE;
    for (int i = 0; i < NUM_CP; i++) begin
      if (cp_idx == CP_IDX_W'(i)) code = acc[i];
    end
    allow = valid & en & acc_permits(code, priv);
    undef = valid & ~allow;
  end

endmodule

// File: rtl/cpx_clk_req.sv
module cpx_clk_req #(
  parameter int NUM_CP = 2
) (
  input  logic [NUM_CP-1:0][1:0] acc,
  output logic                   clk_en
);

  logic [NUM_CP-1:0] live;

  for (genvar g = 0; g < NUM_CP; g++) begin : g_field
    assign live[g] = |acc[g];
  end

  assign clk_en = |live;

endmodule

// File: rtl/cpx_enable_ctrl.sv
module cpx_enable_ctrl
  import cpx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int EN_BIT    = 30,
  parameter int FIELD_LSB = 20,
  parameter int NUM_CP    = 2,
  parameter int SYNC_STG  = 2,
  localparam int CP_IDX_W = (NUM_CP > 1) ? $clog2(NUM_CP) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_sel,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic                reg_priv,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                reg_fault,
  input  logic                insn_valid,
  input  logic [CP_IDX_W-1:0] insn_cp,
  input  logic                insn_priv,
  output logic                insn_allow,
  output logic                insn_undef,
  output logic                cp_enable,
  output logic                cp_clk_en
);

  logic                   rst_n_s;
  logic                   en_w;
  logic [NUM_CP-1:0][1:0] acc_w;

  cpx_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  cpx_regbank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EN_BIT(EN_BIT),
    .FIELD_LSB(FIELD_LSB), .NUM_CP(NUM_CP)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s), .sel(reg_sel), .wr(reg_wr),
    .addr(reg_addr), .wdata(reg_wdata), .priv(reg_priv),
    .rdata(reg_rdata), .fault(reg_fault), .en(en_w), .acc(acc_w)
  );

  cpx_access_check #(.NUM_CP(NUM_CP), .CP_IDX_W(CP_IDX_W)) u_chk (
    .en(en_w), .acc(acc_w), .valid(insn_valid), .cp_idx(insn_cp),
    .priv(insn_priv), .allow(insn_allow), .undef(insn_undef)
  );

  cpx_clk_req #(.NUM_CP(NUM_CP)) u_clk (
    .acc(acc_w), .clk_en(cp_clk_en)
  );

  assign cp_enable = en_w;

  assert_allow_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    insn_allow |-> (cp_enable && insn_valid && !insn_undef));

  assert_unpriv_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (insn_allow && !insn_priv) |-> (acc_w[insn_cp] == 2'b11));

  assert_clk_off_when_closed_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc_w == '0) |-> !cp_clk_en);

  assert_reset_closed_R1: assert property (@(posedge clk)
    !rst_n_s |-> (!cp_enable && !cp_clk_en && !reg_fault && reg_rdata == '0));

endmodule

// File: tb/tb_cpx_enable_ctrl.sv
`timescale 1ns/1ps
module tb_cpx_enable_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_sel, reg_wr, reg_priv;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_fault;
  logic        insn_valid, insn_priv, insn_allow, insn_undef;
  logic [0:0]  insn_cp;
  logic        cp_enable, cp_clk_en;

  int vectors = 0;
  int miscomp = 0;

  // reference state
  bit       m_en;
  bit [1:0] m_f [2];
  bit [31:0] m_rd;
  bit       m_ft;

  always #5 clk = ~clk;

  cpx_enable_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_priv(reg_priv),
    .reg_rdata(reg_rdata), .reg_fault(reg_fault), .insn_valid(insn_valid),
    .insn_cp(insn_cp), .insn_priv(insn_priv), .insn_allow(insn_allow),
    .insn_undef(insn_undef), .cp_enable(cp_enable), .cp_clk_en(cp_clk_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit permits(bit [1:0] f, bit p);
    if (f == 2'b11) return 1'b1;
    if (f == 2'b01) return p;
    return 1'b0;
  endfunction

  task automatic compare_all();
    bit a;
    a = insn_valid && m_en && permits(m_f[insn_cp], insn_priv);
    chk("R4 R3 rdata", reg_rdata, m_rd);
    chk("R5 fault", {31'd0, reg_fault}, {31'd0, m_ft});
    chk("R2 enable", {31'd0, cp_enable}, {31'd0, m_en});
    chk("R8 R9 clk_en", {31'd0, cp_clk_en}, {31'd0, (m_f[0] != 0) || (m_f[1] != 0)});
    chk("R6 R7 allow", {31'd0, insn_allow}, {31'd0, a});
    chk("R7 undef", {31'd0, insn_undef}, {31'd0, insn_valid && !a});
  endtask

  task automatic cycle(input bit s, input bit w, input bit [1:0] ad, input bit [31:0] d,
                       input bit p, input bit iv, input bit ic, input bit ip);
    reg_sel = s; reg_wr = w; reg_addr = ad; reg_wdata = d; reg_priv = p;
    insn_valid = iv; insn_cp = ic; insn_priv = ip;
    @(posedge clk);
    m_rd = 0; m_ft = 0;
    if (s && !p) m_ft = 1;
    else if (s && w) begin
      if (ad == 0) m_en = d[30];
      if (ad == 1) begin m_f[0] = d[21:20]; m_f[1] = d[23:22]; end
    end else if (s) begin
      if (ad == 0) m_rd[30] = m_en;
      if (ad == 1) m_rd = {8'd0, m_f[1], m_f[0], 20'd0};
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input bit iv, input bit ic, input bit ip);
    cycle(0, 0, 0, 0, 0, iv, ic, ip);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscomp++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    reg_sel = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; reg_priv = 0;
    insn_valid = 0; insn_cp = 0; insn_priv = 0;
    m_en = 0; m_f[0] = 0; m_f[1] = 0; m_rd = 0; m_ft = 0;
    repeat (3) @(negedge clk);
    // R1: state held at zero under reset
    chk("R1 rdata", reg_rdata, 32'd0);
    chk("R1 enable", {31'd0, cp_enable}, 32'd0);
    chk("R1 clk_en", {31'd0, cp_clk_en}, 32'd0);
    chk("R1 fault", {31'd0, reg_fault}, 32'd0);
    rst_n = 1'b1;
    repeat (4) idle(0, 0, 0);
    // R1: still closed after release, instruction is undefined
    idle(1, 0, 1);
    chk("R1 undef after reset", {31'd0, insn_undef}, 32'd1);
    // R4: privileged read of enable register returns zero
    cycle(1, 0, 0, 0, 1, 0, 0, 0);
    // R5: unprivileged write refused
    cycle(1, 1, 0, 32'h4000_0000, 0, 0, 0, 0);
    chk("R5 fault pulse", {31'd0, reg_fault}, 32'd1);
    idle(0, 0, 0);
    chk("R5 fault one cycle", {31'd0, reg_fault}, 32'd0);
    chk("R5 enable untouched", {31'd0, cp_enable}, 32'd0);
    // R3: cp0 privileged-only, cp1 full
    cycle(1, 1, 1, 32'h00D0_0000, 1, 1, 1, 0);
    // R9: clock request on while enable still off
    chk("R9 clk_en without enable", {30'd0, cp_enable, cp_clk_en}, 32'd1);
    chk("R7 denied while disabled", {31'd0, insn_undef}, 32'd1);
    // R2: only bit 30 matters
    cycle(1, 1, 0, 32'hBFFF_FFFF, 1, 0, 0, 0);
    chk("R2 other bits ignored", {31'd0, cp_enable}, 32'd0);
    cycle(1, 1, 0, 32'h4000_0000, 1, 0, 0, 0);
    chk("R2 enable set", {31'd0, cp_enable}, 32'd1);
    // R6: privilege rules per field
    idle(1, 0, 0);
    chk("R6 priv-only refuses user", {31'd0, insn_undef}, 32'd1);
    idle(1, 0, 1);
    chk("R6 priv-only allows priv", {31'd0, insn_allow}, 32'd1);
    idle(1, 1, 0);
    chk("R6 full allows user", {31'd0, insn_allow}, 32'd1);
    // R3: readback positions
    cycle(1, 0, 1, 0, 1, 0, 0, 0);
    chk("R3 readback", reg_rdata, 32'h00D0_0000);
    // R6: reserved code stored, denies, clock still requested
    cycle(1, 1, 1, 32'h0020_0000, 1, 1, 0, 1);
    chk("R6 reserved denies", {31'd0, insn_undef}, 32'd1);
    cycle(1, 0, 1, 0, 1, 0, 0, 0);
    chk("R6 reserved readback", reg_rdata, 32'h0020_0000);
    // R5: unprivileged read returns zero
    cycle(1, 0, 1, 0, 0, 0, 0, 0);
    chk("R5 read zero", reg_rdata, 32'd0);
    // R4: unused addresses
    cycle(1, 1, 2, 32'hFFFF_FFFF, 1, 0, 0, 0);
    cycle(1, 1, 3, 32'hFFFF_FFFF, 1, 0, 0, 0);
    cycle(1, 0, 3, 0, 1, 0, 0, 0);
    chk("R4 unused address", reg_rdata, 32'd0);
    // R8: clearing fields drops the clock request
    cycle(1, 1, 1, 32'h0, 1, 0, 0, 0);
    chk("R8 clk off", {31'd0, cp_clk_en}, 32'd0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit [31:0] d;
      d = $urandom;
      if ($urandom_range(0, 3) == 0) d[30] = ~d[30];
      cycle(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
            d, bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

endmodule